// File: doc/BRIEF.md
# Shadow Write Zone Decoder

This block watches every CPU write on a 24-bit bus and decides whether that write must also be copied into the two video RAM banks at the top of physical memory. The decision depends on the page the write hits, on whether the bank number is even or odd, on a 6-bit shadow control register held inside the block, and on a level input that selects whether shadowing is confined to the two lowest banks or extended to every fast RAM bank.

When a write qualifies, the block raises a one-cycle enable together with the physical target address. The target is the write's offset within the video region: the low 17 bits of the write address, added to the base of the final 128 KB of RAM. That base sits directly after the `FAST_BANKS` banks of fast RAM. Arbitration toward the slow video memory, and the memories themselves, belong to the blocks that consume this output.

Top module: `shadow_zone_decoder`

## Requirements
- R1: After reset the shadow control register holds 6'h08. With that value, a write to page $20 of bank $00 is shadowed and a write to $6000 of bank $01 is not.
- R2: A write to $0400-$07FF in an eligible bank is shadowed exactly when control bit 0 is clear, in both even and odd banks.
- R3: With `TEXT2_EN`=1, a write to $0800-$0BFF in an eligible bank is shadowed exactly when control bit 5 is clear. With `TEXT2_EN`=0 it is never shadowed.
- R4: In even banks, $2000-$3FFF is shadowed exactly when bit 1 is clear, and $4000-$5FFF exactly when bit 2 is clear.
- R5: In odd banks, $2000-$3FFF is inhibited only when (bit 1 or bit 4) and bit 3 are all set as written. $4000-$5FFF follows the same rule with bit 2 in place of bit 1.
- R6: $6000-$9FFF is shadowed only in odd banks, and only when bit 3 is clear. In even banks it is never shadowed.
- R7: While `all_banks` is low, writes to banks $02 and above are never shadowed. While it is high, those banks follow the same zone rules as banks $00/$01, with the bank's bit 16 giving the parity.
- R8: Writes to pages outside the zones above are never shadowed. This covers $0000-$03FF, $0C00-$1FFF, $A000-$FFFF and the I/O space $C000-$CFFF. Writes to banks at or above `FAST_BANKS` are never shadowed either, which covers banks $E0/$E1 and the ROM banks.
- R9: When `shd_en` is high, `shd_addr` equals `FAST_BANKS`*65536 plus bits 16:0 of the write address.
- R10: `shd_en` rises in the cycle after the clock edge that samples `wr_en` high, and lasts one cycle per sampled write. It is low during reset and whenever no write was sampled.
- R11: A control load is sampled at a clock edge and governs writes sampled at later edges. A write sampled at the same edge as the load is judged with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_load | input | 1 | Load strobe for the shadow control register |
| ctl_data | input | 6 | New control value; a set bit inhibits its zone |
| all_banks | input | 1 | High: shadow in every fast RAM bank; low: banks $00/$01 only |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 24 | CPU write address (bank in bits 23:16) |
| shd_en | output | 1 | Registered shadow-write enable pulse |
| shd_addr | output | PHYS_AW (20 by default) | Physical video RAM target address |

## Verification
A wrong control register value or a misdecoded zone shows up at the ports one cycle after the next write that lands in an affected zone. It appears either as a missing `shd_en` pulse or as a spurious one, so the bench mixes directed writes against every inhibit bit with a long random sweep. A stale or misordered control load is exposed by a write placed in the same cycle as the load and another in the cycle after it. A wrong target offset is visible on `shd_addr` in the same cycle as the pulse.

// File: rtl/shz_pkg.sv
package shz_pkg;

  typedef enum logic [2:0] {
    Z_NONE   = 3'd0,
    Z_TEXT1  = 3'd1,
    Z_TEXT2  = 3'd2,
    Z_GFX1   = 3'd3,
    Z_GFX2   = 3'd4,
    Z_GTAIL  = 3'd5
  } zone_t;

  localparam int CTL_W = 6;

  localparam int B_TEXT1 = 0;
  localparam int B_GFX1  = 1;
  localparam int B_GFX2  = 2;
  localparam int B_SUPER = 3;
  localparam int B_AUXG  = 4;
  localparam int B_TEXT2 = 5;

endpackage

// File: rtl/shz_ctl_reg.sv
module shz_ctl_reg #(
  parameter int W = 6,
  parameter logic [W-1:0] RESET_VAL = 6'h08
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VAL;
    else if (load) q <= d;
  end

  // R11: a sampled load is visible one cycle later
  p_load_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/shz_zone_map.sv
module shz_zone_map
  import shz_pkg::*;
(
  input  logic [7:0] page,
  output zone_t      zone
);

  always_comb begin
    zone = Z_NONE;
    if (page[7:2] == 6'b000001)                     zone = Z_TEXT1;
    else if (page[7:2] == 6'b000010)                zone = Z_TEXT2;
    else if (page[7:5] == 3'b001)                   zone = Z_GFX1;
    else if (page[7:5] == 3'b010)                   zone = Z_GFX2;
    else if (page[7:5] == 3'b011 || page[7:5] == 3'b100) zone = Z_GTAIL;
  end

endmodule

// File: rtl/shz_inhibit.sv
module shz_inhibit
  import shz_pkg::*;
#(
  parameter bit TEXT2_EN = 1'b1
) (
  input  zone_t            zone,
  input  logic             odd_bank,
  input  logic             bank_ok,
  input  logic [CTL_W-1:0] ctl,
  output logic             allow
);

  logic text2_allow;
  logic gfx1_odd_inh;
  logic gfx2_odd_inh;
  logic zone_allow;

  generate
    if (TEXT2_EN) begin : g_text2
      assign text2_allow = !ctl[B_TEXT2];
    end else begin : g_no_text2
      assign text2_allow = 1'b0;
    end
  endgenerate

  assign gfx1_odd_inh = (ctl[B_GFX1] | ctl[B_AUXG]) & ctl[B_SUPER];
  assign gfx2_odd_inh = (ctl[B_GFX2] | ctl[B_AUXG]) & ctl[B_SUPER];

  always_comb begin
    unique case (zone)
      Z_TEXT1: zone_allow = !ctl[B_TEXT1];
      Z_TEXT2: zone_allow = text2_allow;
      Z_GFX1:  zone_allow = odd_bank ? !gfx1_odd_inh : !ctl[B_GFX1];
      Z_GFX2:  zone_allow = odd_bank ? !gfx2_odd_inh : !ctl[B_GFX2];
      Z_GTAIL: zone_allow = odd_bank & !ctl[B_SUPER];
      default: zone_allow = 1'b0;
    endcase
  end

  assign allow = bank_ok & zone_allow;

  // R6: the graphics tail never opens in an even bank
  always_comb begin
    if (zone == Z_GTAIL && !odd_bank) begin
      p_tail_even_r6: assert (!allow);
    end
  end

endmodule

// File: rtl/shadow_zone_decoder.sv
module shadow_zone_decoder
  import shz_pkg::*;
#(
  parameter int FAST_BANKS = 8,
  parameter bit TEXT2_EN   = 1'b1,
  localparam int PHYS_AW   = $clog2((FAST_BANKS + 2) * 65536)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_load,
  input  logic [CTL_W-1:0]   ctl_data,
  input  logic               all_banks,
  input  logic               wr_en,
  input  logic [23:0]        wr_addr,
  output logic               shd_en,
  output logic [PHYS_AW-1:0] shd_addr
);

  localparam logic [PHYS_AW-1:0] SHADOW_BASE = PHYS_AW'(FAST_BANKS * 65536);
  localparam logic [PHYS_AW-1:0] SHADOW_END  = PHYS_AW'((FAST_BANKS + 2) * 65536 - 1);
  localparam logic [7:0]         BANK_LIMIT  = 8'(FAST_BANKS);

  logic [CTL_W-1:0] ctl_q;
  zone_t            zone;
  logic [7:0]       bank;
  logic             has_ram;
  logic             low_pair;
  logic             bank_ok;
  logic             allow;

  shz_ctl_reg #(.W(CTL_W), .RESET_VAL(6'h08)) i_ctl (
    .clk  (clk),
    .rst  (rst),
    .load (ctl_load),
    .d    (ctl_data),
    .q    (ctl_q)
  );

  shz_zone_map i_map (
    .page (wr_addr[15:8]),
    .zone (zone)
  );

  assign bank     = wr_addr[23:16];
  assign has_ram  = bank < BANK_LIMIT;
  assign low_pair = (bank[7:1] == 7'd0);
  assign bank_ok  = has_ram & (low_pair | all_banks);

  shz_inhibit #(.TEXT2_EN(TEXT2_EN)) i_inh (
    .zone     (zone),
    .odd_bank (wr_addr[16]),
    .bank_ok  (bank_ok),
    .ctl      (ctl_q),
    .allow    (allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_en   <= 1'b0;
      shd_addr <= '0;
    end else begin
      shd_en <= wr_en & allow;
      if (wr_en) shd_addr <= SHADOW_BASE + PHYS_AW'(wr_addr[16:0]);
    end
  end

  // R10: no pulse without a sampled write
  p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !shd_en);

  // R8: I/O page never shadowed
  p_io_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[15:12] == 4'hC) |=> !shd_en);

  // R7: high banks gated by all_banks
  p_slow_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !all_banks && wr_addr[23:17] != 7'd0) |=> !shd_en);

  // R6: odd tail inhibited by the super bit
  p_tail_inh_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_q[B_SUPER] && (wr_addr[15:13] == 3'b011 || wr_addr[15:13] == 3'b100))
      |=> !shd_en);

  // R9: target always lands in the video region
  p_target_range_r9: assert property (@(posedge clk) disable iff (rst)
    shd_en |-> (shd_addr >= SHADOW_BASE && shd_addr <= SHADOW_END));

endmodule

// File: tb/test_shadow_zone_decoder.sv
module test_shadow_zone_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int FAST_BANKS = 8;
  localparam int PHYS_AW = $clog2((FAST_BANKS + 2) * 65536);

  logic               clk = 1'b0;
  logic               rst;
  logic               ctl_load;
  logic [5:0]         ctl_data;
  logic               all_banks;
  logic               wr_en;
  logic [23:0]        wr_addr;
  logic               shd_en;
  logic [PHYS_AW-1:0] shd_addr;

  int checks = 0;
  int fails  = 0;
  int m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_zone_decoder #(.FAST_BANKS(FAST_BANKS)) i_shadow_zone_decoder (
    .clk(clk), .rst(rst), .ctl_load(ctl_load), .ctl_data(ctl_data),
    .all_banks(all_banks), .wr_en(wr_en), .wr_addr(wr_addr),
    .shd_en(shd_en), .shd_addr(shd_addr)
  );

  // Reference decision written from the requirements
  function automatic bit ref_decide(input int a, input int c, input bit spd, output string tag);
    int bank = (a >> 16) & 'hFF;
    int off  = a & 'hFFFF;
    bit odd  = bank[0];
    bit b0 = c[0], b1 = c[1], b2 = c[2], b3 = c[3], b4 = c[4], b5 = c[5];
    tag = "R8";
    if (bank >= FAST_BANKS) return 0;
    if (bank >= 2 && !spd) begin tag = "R7"; return 0; end
    if (off >= 'h0400 && off < 'h0800) begin tag = "R2"; return !b0; end
    if (off >= 'h0800 && off < 'h0C00) begin tag = "R3"; return !b5; end
    if (off >= 'h2000 && off < 'h4000) begin
      if (odd) begin tag = "R5"; return !((b1 || b4) && b3); end
      tag = "R4"; return !b1;
    end
    if (off >= 'h4000 && off < 'h6000) begin
      if (odd) begin tag = "R5"; return !((b2 || b4) && b3); end
      tag = "R4"; return !b2;
    end
    if (off >= 'h6000 && off < 'hA000) begin tag = "R6"; return odd && !b3; end
    return 0;
  endfunction

  task automatic check_en(input bit exp, input string tag);
    checks++;
    if (shd_en !== exp) begin
      fails++;
      $display("FAIL %s shd_en actual=%0b expected=%0b", tag, shd_en, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input bit w, input int a, input bit ld, input int d, input bit spd);
    bit exp;
    string tag;
    int exp_addr;
    wr_en = w; wr_addr = a[23:0]; ctl_load = ld; ctl_data = d[5:0]; all_banks = spd;
    exp = w && ref_decide(a, m_ctl, spd, tag);
    if (!w) tag = "R10";
    exp_addr = FAST_BANKS * 65536 + (a & 'h1FFFF);
    if (ld) m_ctl = d & 'h3F;
    @(negedge clk);
    check_en(exp, tag);
    if (exp) begin
      checks++;
      if (shd_addr !== exp_addr[PHYS_AW-1:0]) begin
        fails++;
        $display("FAIL R9 shd_addr actual=%h expected=%h", shd_addr, exp_addr);
      end
    end
  endtask

  task automatic wr(input int a, input bit spd);
    step(1'b1, a, 1'b0, 0, spd);
  endtask

  task automatic load(input int d);
    step(1'b0, 0, 1'b1, d, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b1; wr_addr = 24'h002000; ctl_load = 1'b0; ctl_data = '0; all_banks = 1'b1;
    m_ctl = 'h08;
    repeat (3) @(negedge clk);
    check_en(1'b0, "R10");               // low during reset despite write strobe
    rst = 1'b0;

    // R1: reset value 08 shadows bank 0 graphics, not odd tail
    wr('h002000, 0);
    wr('h016000, 0);
    wr('h012000, 0);                      // R5 odd: (b1|b4)&b3 false
    wr('h000400, 0);                      // R2
    wr('h000800, 0);                      // R3
    wr('h00C000, 0);                      // R8 I/O
    wr('h00D000, 0);                      // R8
    wr('h000100, 0);                      // R8
    wr('h001000, 0);                      // R8
    wr('h020400, 0);                      // R7 gated
    wr('h020400, 1);                      // R7 open, R9 address
    wr('h036000, 1);                      // R6 inhibited by bit3
    wr('h080400, 1);                      // R8 no RAM
    wr('hE00400, 1);                      // R8 slow bank
    wr('hFF2000, 1);                      // R8 ROM
    step(1'b0, 'h002000, 0, 0, 0);        // R10 idle

    // R11: write in the load cycle uses old value
    step(1'b1, 'h016000, 1'b1, 'h00, 0);
    wr('h016000, 0);                      // R6 now open
    wr('h006000, 0);                      // R6 even never
    wr('h017FFF, 0);
    load('h02);
    wr('h002000, 0);                      // R4
    wr('h012000, 0);                      // R5
    load('h0A);
    wr('h012000, 0);                      // R5 inhibited
    wr('h014000, 0);                      // R5 open
    load('h18);
    wr('h012000, 0);                      // R5 via bit4
    wr('h014000, 0);
    wr('h002000, 0);                      // R4 even ignores bit4
    load('h04);
    wr('h004000, 0);                      // R4
    wr('h014000, 0);
    load('h01);
    wr('h000500, 0);                      // R2
    wr('h0307FF, 1);                      // R2 odd bank
    load('h20);
    wr('h000900, 0);                      // R3
    wr('h010A00, 0);
    load('h00);
    wr('h000400, 0); wr('h010400, 0); wr('h002000, 0);  // R10 back-to-back

    // random sweep
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 7);
      int banks[8] = '{0, 1, 2, 3, 7, 8, 'hE0, 'hFF};
      int a = (banks[sel] << 16) | $urandom_range(0, 'hFFFF);
      bit ld = ($urandom_range(0, 7) == 0);
      step($urandom_range(0, 3) != 0, a, ld, $urandom_range(0, 63), $urandom_range(0, 1) == 1);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule